// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A one-cycle start strobe captures a 10-bit starting column, a 3-bit burst-length code, an ordering bit (linear or XOR), a read/write flag and a write-single-beat mode bit. From the next cycle on, the block presents one column per clock with a valid flag. It also raises a last flag on the final beat of a finite burst.

For finite bursts, the beats stay inside the aligned block whose size equals the burst length, and the column bits above that block never move. A page-wide burst walks the whole 1024-column row and wraps at the row end. It runs until a terminate pulse arrives. An unsupported configuration raises an error flag for one cycle, and no addresses are issued. The command sequencer around the block uses the columns and flags to drive the column address pins. CAS latency and data capture are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: Length code len_code_i maps 3'b000 to 1 beat, 3'b001 to 2 beats, 3'b010 to 4 beats and 3'b011 to 8 beats. last_o is high together with valid_o on the final beat only, and valid_o drops the cycle after it.
- R2: For a 1-beat burst, the ordering bit itlv_i has no effect: the single beat carries the start column.
- R3: For 2-, 4- and 8-beat bursts, column bits above the low 1, 2 or 3 bits equal those of the start column on every beat.
- R4: With itlv_i=0, beat k carries low bits (start + k) modulo the length. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R5: With itlv_i=1, beat k carries low bits start XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R6: Code 3'b111 with itlv_i=0 is a page-wide burst. Beat k carries (start + k) modulo 1024, last_o never rises, and the burst ends only on terminate.
- R7: A term_i pulse sampled while a burst is active ends it. The beat present in that cycle is the final valid beat, and valid_o is low the next cycle.
- R8: A start with code 3'b100, 3'b101 or 3'b110, or with code 3'b111 and itlv_i=1, raises err_o for exactly the next cycle and produces no valid beat.
- R9: With wr_single_i=1, a write start (is_wr_i=1) gives a single beat at the start column. A read start still uses the programmed length.
- R10: The first beat appears the cycle after start_i, and beats follow on consecutive cycles. A start during a burst abandons it, and the new burst's first beat follows on the next cycle.
- R11: While reset is held, and right after its release, valid_o, last_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the inputs below |
| col_i | input | 10 | Starting column |
| len_code_i | input | 3 | Burst-length code |
| itlv_i | input | 1 | 0 linear order, 1 XOR order |
| wr_single_i | input | 1 | Writes access a single column |
| is_wr_i | input | 1 | 1 write, 0 read |
| term_i | input | 1 | Terminate the active burst |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | Previous start was rejected |

## Verification
On every cycle, the assertions check several rules. The upper column bits must hold still within a finite burst, and linear beats must step by one inside the block. last_o must never appear without valid_o or during a page-wide burst. A terminate or a last beat must be followed by an idle cycle, and an error must never come with a valid beat. The exact beat orders need the bench's scenarios, because only those compare each column against an expected sequence. These are the XOR permutations, the wrap points of the block and the page, and the single-beat write override. The restart timing and the length decode are likewise shown only by the bench.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W   = 10;
  localparam int LCODE_W = 3;

  localparam logic [LCODE_W-1:0] LC_PAGE = 3'b111;
endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic [LCODE_W-1:0] len_code_i,
  input  logic               itlv_i,
  input  logic               single_i,
  output logic [CW-1:0]      mask_o,
  output logic               page_o,
  output logic               itlv_o,
  output logic               err_o
);
  logic finite;
  logic page_req;

  assign finite   = ~len_code_i[2];
  assign page_req = (len_code_i == LC_PAGE);

  always_comb begin
    err_o  = ~finite & ~(page_req & ~itlv_i);
    page_o = page_req & ~single_i;
    itlv_o = itlv_i;
    if (single_i)
      mask_o = '0;
    else if (page_req)
      mask_o = '1;
    else
      mask_o = ~({CW{1'b1}} << len_code_i[1:0]);
  end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] beat_i,
  input  logic [CW-1:0] mask_i,
  input  logic          itlv_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] low_seq, low_xor;

  assign low_seq = start_i + beat_i;
  assign low_xor = start_i ^ beat_i;

  for (genvar i = 0; i < CW; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (itlv_i ? low_xor[i] : low_seq[i]) : start_i[i];
  end
endmodule

// File: rtl/bcg_ctl.sv
module bcg_ctl #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bad_i,
  input  logic          term_i,
  input  logic [CW-1:0] col_i,
  input  logic [CW-1:0] mask_i,
  input  logic          page_i,
  input  logic          itlv_i,
  output logic          active_o,
  output logic          last_o,
  output logic          err_o,
  output logic [CW-1:0] start_o,
  output logic [CW-1:0] beat_o,
  output logic [CW-1:0] mask_o,
  output logic          page_o,
  output logic          itlv_o
);
  logic          active_q, err_q, page_q, itlv_q;
  logic [CW-1:0] beat_q, start_q, mask_q;
  logic          at_end;

  assign at_end = ~page_q & (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      page_q   <= 1'b0;
      itlv_q   <= 1'b0;
      beat_q   <= '0;
      start_q  <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      err_q    <= bad_i;
      active_q <= ~bad_i;
      beat_q   <= '0;
      if (!bad_i) begin
        start_q <= col_i;
        mask_q  <= mask_i;
        page_q  <= page_i;
        itlv_q  <= itlv_i;
      end
    end else begin
      err_q <= 1'b0;
      if (active_q) begin
        if (term_i || at_end) active_q <= 1'b0;
        else                  beat_q   <= beat_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q & at_end;
  assign err_o    = err_q;
  assign start_o  = start_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign page_o   = page_q;
  assign itlv_o   = itlv_q;

  AST_TERM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && term_i && !start_i |=> !active_q); // R7
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_q); // R1
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && page_q |-> !last_o); // R6
  AST_ERR_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !active_q); // R8
  AST_START_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !bad_i |=> active_q && beat_q == '0); // R10
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [LCODE_W-1:0] len_code_i,
  input  logic               itlv_i,
  input  logic               wr_single_i,
  input  logic               is_wr_i,
  input  logic               term_i,
  output logic [COL_W-1:0]   col_o,
  output logic               valid_o,
  output logic               last_o,
  output logic               err_o
);
  logic [COL_W-1:0] dec_mask, st_q, beat_q, mask_q;
  logic             dec_page, dec_itlv, dec_err, page_q, itlv_q;

  bcg_decode #(.CW(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .itlv_i     (itlv_i),
    .single_i   (wr_single_i & is_wr_i),
    .mask_o     (dec_mask),
    .page_o     (dec_page),
    .itlv_o     (dec_itlv),
    .err_o      (dec_err)
  );

  bcg_ctl #(.CW(COL_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .bad_i    (dec_err),
    .term_i   (term_i),
    .col_i    (col_i),
    .mask_i   (dec_mask),
    .page_i   (dec_page),
    .itlv_i   (dec_itlv),
    .active_o (valid_o),
    .last_o   (last_o),
    .err_o    (err_o),
    .start_o  (st_q),
    .beat_o   (beat_q),
    .mask_o   (mask_q),
    .page_o   (page_q),
    .itlv_o   (itlv_q)
  );

  bcg_col_map #(.CW(COL_W)) u_map (
    .start_i (st_q),
    .beat_i  (beat_q),
    .mask_i  (mask_q),
    .itlv_i  (itlv_q),
    .col_o   (col_o)
  );

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R1
  AST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && !$past(start_i) && !page_q
    |-> ((col_o ^ $past(col_o)) & ~mask_q) == '0); // R3
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && !$past(start_i) && !itlv_q
    |-> (col_o & mask_q) == (($past(col_o) + 1'b1) & mask_q)); // R4
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !$past(start_i, 1) |-> 1'b0); // R8
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       itlv_i = 1'b0, wr_single_i = 1'b0, is_wr_i = 1'b0, term_i = 1'b0;
  logic [9:0] col_o;
  logic       valid_o, last_o, err_o;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  burst_col_gen u_burst_col_gen (.*);

  typedef struct packed {
    logic [2:0]  code;
    logic        itlv;
    logic        wr;
    logic        wrs;
    logic [9:0]  st;
    logic [3:0]  n;
    logic [79:0] exp;
  } vec_t;

  localparam vec_t TAB [0:8] = '{
    '{3'b011, 1'b0, 1'b0, 1'b0, 10'd5,    4'd8, {10'd4,10'd3,10'd2,10'd1,10'd0,10'd7,10'd6,10'd5}},
    '{3'b011, 1'b1, 1'b0, 1'b0, 10'd5,    4'd8, {10'd2,10'd3,10'd0,10'd1,10'd6,10'd7,10'd4,10'd5}},
    '{3'b010, 1'b0, 1'b0, 1'b0, 10'd1014, 4'd4, {40'd0,10'd1013,10'd1012,10'd1015,10'd1014}},
    '{3'b010, 1'b1, 1'b0, 1'b0, 10'd13,   4'd4, {40'd0,10'd14,10'd15,10'd12,10'd13}},
    '{3'b001, 1'b0, 1'b0, 1'b0, 10'd513,  4'd2, {60'd0,10'd512,10'd513}},
    '{3'b000, 1'b1, 1'b0, 1'b0, 10'd341,  4'd1, {70'd0,10'd341}},
    '{3'b011, 1'b0, 1'b1, 1'b1, 10'd19,   4'd1, {70'd0,10'd19}},
    '{3'b011, 1'b0, 1'b0, 1'b1, 10'd19,   4'd8, {10'd18,10'd17,10'd16,10'd23,10'd22,10'd21,10'd20,10'd19}},
    '{3'b011, 1'b1, 1'b0, 1'b0, 10'd1023, 4'd8, {10'd1016,10'd1017,10'd1018,10'd1019,10'd1020,10'd1021,10'd1022,10'd1023}}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] code, input logic it, input logic wr,
                    input logic wrs, input logic [9:0] st);
    @(negedge clk_i);
    start_i = 1'b1; len_code_i = code; itlv_i = it; is_wr_i = wr;
    wr_single_i = wrs; col_i = st;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 valid in reset", valid_o, 0);
    chk("R11 err in reset", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 valid after reset", valid_o, 0);
    chk("R11 last after reset", last_o, 0);

    // R1 R2 R3 R4 R5 R9 table walk
    foreach (TAB[v]) begin
      go(TAB[v].code, TAB[v].itlv, TAB[v].wr, TAB[v].wrs, TAB[v].st);
      for (int b = 0; b < int'(TAB[v].n); b++) begin
        chk($sformatf("R1/R4/R5 vec%0d beat%0d valid", v, b), valid_o, 1);
        chk($sformatf("R3/R4/R5/R9 vec%0d beat%0d col", v, b), col_o, int'(TAB[v].exp[b*10 +: 10]));
        chk($sformatf("R1 vec%0d beat%0d last", v, b), last_o, (b == int'(TAB[v].n) - 1) ? 1 : 0);
        @(negedge clk_i);
      end
      chk($sformatf("R1 vec%0d idle after", v), valid_o, 0);
    end

    // R6 page-wide burst across the row end, then R7 terminate
    go(3'b111, 1'b0, 1'b0, 1'b0, 10'd1020);
    for (int b = 0; b < 1030; b++) begin
      if (col_o !== 10'((1020 + b) % 1024) || valid_o !== 1'b1 || last_o !== 1'b0)
        chk($sformatf("R6 page beat%0d col", b), col_o, (1020 + b) % 1024);
      if (b == 4 || b == 1029) chk($sformatf("R6 page beat%0d", b), col_o, (1020 + b) % 1024);
      if (b == 1029) term_i = 1'b1;
      @(negedge clk_i);
    end
    term_i = 1'b0;
    chk("R7 idle after terminate", valid_o, 0);

    // R7 terminate mid finite burst
    go(3'b011, 1'b0, 1'b0, 1'b0, 10'd40);
    @(negedge clk_i);
    chk("R7 beat1 col", col_o, 41);
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    chk("R7 finite stop", valid_o, 0);

    // R8 reserved codes and XOR page request
    for (int c = 4; c < 8; c++) begin
      go(3'(c), (c == 7) ? 1'b1 : 1'b0, 1'b0, 1'b0, 10'd8);
      chk($sformatf("R8 code%0d err", c), err_o, 1);
      chk($sformatf("R8 code%0d no valid", c), valid_o, 0);
      @(negedge clk_i);
      chk($sformatf("R8 code%0d err drops", c), err_o, 0);
      chk($sformatf("R8 code%0d still idle", c), valid_o, 0);
    end

    // R10 restart mid burst
    go(3'b011, 1'b0, 1'b0, 1'b0, 10'd100);
    chk("R10 first beat next cycle", col_o, 100);
    start_i = 1'b1; len_code_i = 3'b001; col_i = 10'd301; itlv_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 restart col", col_o, 301);
    @(negedge clk_i);
    chk("R10 restart wrap", col_o, 300);
    chk("R10 restart last", last_o, 1);
    @(negedge clk_i);
    chk("R10 restart idle", valid_o, 0);

    finish_run();
  end
endmodule